// File: doc/BRIEF.md
# Page Write-Protection Unit for a Tightly Coupled RAM

This block sits in the write path of a small tightly coupled RAM and blocks writes one 1 KB page at a time. It holds a protection mask with one bit per page. Software can set bits in this mask through a register-write port. No software write can clear a bit; only the synchronous system reset clears them. Every access presented on the memory-access port passes straight through to the RAM side in the same cycle. The one exception is a write that lands inside the RAM window on a protected page. That write leaves with its write enable and all byte strobes forced low, and the block raises an error pulse.

The RAM window starts at a parameterised base address (default 0x1000_0000) and holds `NUM_PAGES` pages (4, 8 or 16). The page index is taken from the address bits just above the 1 KB offset, which are bits [13:10] when there are 16 pages. Reads are never touched. Addresses outside the window are never checked.

Top module: `wp_page_guard`

## Requirements
- R1: After reset the protection mask (`prot_mask_o`) is all zero and `err_o` is low.
- R2: A cycle with `cfg_wr_en` high sets every mask bit whose `cfg_wr_data` bit is 1. The new mask appears on `prot_mask_o` after that clock edge.
- R3: A `cfg_wr_data` bit of 0 never clears a mask bit. A set bit stays set until reset, and reset clears all bits.
- R4: A write (`acc_valid`=1, `acc_we`=1) to an in-window page whose mask bit is set leaves in the same cycle with `mem_we`=0 and `mem_strb`=0. Page n covers base+n*0x400 to base+n*0x400+0x3FF, and the page index is address bits [10 +: log2(NUM_PAGES)].
- R5: `err_o` is high for exactly one cycle, the cycle after each blocked write cycle, and is low otherwise.
- R6: Reads (`acc_we`=0) pass with unchanged strobes to any page, protected or not, and never raise `err_o`.
- R7: Writes to unprotected in-window pages pass with `mem_we` and `mem_strb` equal to the inputs, and raise no error.
- R8: Accesses whose address is outside [base, base+NUM_PAGES*0x400) pass unchanged and raise no error, even when their index bits match a protected page.
- R9: Each access is judged against the mask as it stood before the clock edge. A configuration write in the same cycle as an access affects only later accesses.
- R10: `mem_valid` and `mem_addr` always equal `acc_valid` and `acc_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| cfg_wr_en | input | 1 | Protection register write strobe |
| cfg_wr_data | input | NUM_PAGES | Bits to set in the protection mask |
| prot_mask_o | output | NUM_PAGES | Current protection mask |
| acc_valid | input | 1 | Access present |
| acc_addr | input | ADDR_W | Access byte address |
| acc_we | input | 1 | Access is a write |
| acc_strb | input | DATA_W/8 | Byte strobes |
| mem_valid | output | 1 | Access to RAM |
| mem_addr | output | ADDR_W | Address to RAM |
| mem_we | output | 1 | Write enable to RAM, gated |
| mem_strb | output | DATA_W/8 | Byte strobes to RAM, gated |
| err_o | output | 1 | One-cycle pulse after a blocked write |

## Verification
The bench builds the block with `NUM_PAGES` = 8, a 32-bit address and 32-bit data, and keeps the default base address. With only eight pages, the window ends at 0x1000_1FFF. Addresses such as 0x1000_2C00 then carry the index bits of a protected page but lie outside the window, so the out-of-window rule can be told apart from the page decode. The eight-bit mask is also narrow enough for the bench to drive set-only and zero-write patterns over every bit. It also covers page edges at +0x3FF and +0x400 and a configuration write in the same cycle as an access.

// File: rtl/wp_pkg.sv
// Package: shared constants and helpers for the page write-protection unit.
// Assumes byte addressing and a power-of-two page count.
package wp_pkg;
    // Byte offset width within one 1 KB page.
    localparam int unsigned WP_PAGE_SHIFT = 10;
    // Bytes in one page.
    localparam int unsigned WP_PAGE_BYTES = 1 << WP_PAGE_SHIFT;

    // Width of the page index for a given page count (at least 1).
    function automatic int unsigned wp_idx_w(input int unsigned pages);
        return (pages > 1) ? $clog2(pages) : 1;
    endfunction
endpackage

// File: rtl/wp_mask_reg.sv
// Module: set-only protection mask. Software can set bits; only the
// synchronous active-low reset clears them. Assumes one write per cycle.
module wp_mask_reg #(
    parameter int unsigned NUM_PAGES = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [NUM_PAGES-1:0] wr_data,
    output logic [NUM_PAGES-1:0] mask
);
    logic [NUM_PAGES-1:0] mask_q;

    // Accumulate set requests; zeros leave the bits as they are.
    always_ff @(posedge clk) begin
        if (!rst_n)     mask_q <= '0;
        else if (wr_en) mask_q <= mask_q | wr_data;
    end

    assign mask = mask_q;

    // R3: no mask bit ever falls while out of reset.
    a_r3_never_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((mask_q & $past(mask_q)) == $past(mask_q)));

    // R2: every requested bit is set after the write.
    a_r2_bits_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(rst_n)) |=> ((mask_q & $past(wr_data)) == $past(wr_data)));
endmodule

// File: rtl/wp_page_decode.sv
// Module: window and page decode. Gets the address bits above the page
// offset and returns a one-hot page select, which is all zero outside
// the RAM window. Assumes BASE is aligned to the window size.
module wp_page_decode #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned NUM_PAGES = 16,
    parameter logic [ADDR_W-1:0] BASE = 32'h1000_0000
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [ADDR_W-wp_pkg::WP_PAGE_SHIFT-1:0] page_addr,
    output logic                                   in_window,
    output logic [NUM_PAGES-1:0]                   page_sel
);
    localparam int unsigned IDX_W = wp_pkg::wp_idx_w(NUM_PAGES);
    localparam int unsigned TAG_W = ADDR_W - wp_pkg::WP_PAGE_SHIFT - IDX_W;
    localparam logic [TAG_W-1:0] BASE_TAG = BASE[ADDR_W-1 -: TAG_W];

    logic [IDX_W-1:0] idx;

    // Split the page address into window tag and page index.
    always_comb begin
        in_window = (page_addr[ADDR_W-wp_pkg::WP_PAGE_SHIFT-1 -: TAG_W] == BASE_TAG);
        idx       = page_addr[IDX_W-1:0];
    end

    // One select line per page.
    for (genvar g = 0; g < NUM_PAGES; g++) begin : g_sel
        assign page_sel[g] = in_window && (idx == IDX_W'(g));
    end

    // R8: never more than one page selected, none outside the window.
    a_r8_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(page_sel) && (in_window || (page_sel == '0)));
endmodule

// File: rtl/wp_write_gate.sv
// Module: write gate. Passes every access through and suppresses the
// write enable and strobes of writes that hit a protected page. It
// registers a one-cycle error pulse for each blocked write.
// Assumes page_sel and mask are aligned bit for bit.
module wp_write_gate #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned STRB_W    = 4,
    parameter int unsigned NUM_PAGES = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PAGES-1:0] page_sel,
    input  logic [NUM_PAGES-1:0] mask,
    input  logic                 acc_valid,
    input  logic [ADDR_W-1:0]    acc_addr,
    input  logic                 acc_we,
    input  logic [STRB_W-1:0]    acc_strb,
    output logic                 mem_valid,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic                 mem_we,
    output logic [STRB_W-1:0]    mem_strb,
    output logic                 err_o
);
    logic blocked;
    logic err_q;

    // Decide blocking and drive the RAM side.
    always_comb begin
        blocked   = acc_valid && acc_we && (|(page_sel & mask));
        mem_valid = acc_valid;
        mem_addr  = acc_addr;
        mem_we    = blocked ? 1'b0 : acc_we;
        mem_strb  = blocked ? '0 : acc_strb;
    end

    // Error pulse one cycle after a blocked write.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= blocked;
    end

    assign err_o = err_q;

    // R6: reads keep their strobes.
    a_r6_read_pass: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_we |-> (mem_strb == acc_strb && !mem_we));

    // R4: a suppressed write has no strobes left.
    a_r4_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_we && !mem_we) |-> (mem_strb == '0));

    // R5: a suppressed write is followed by an error pulse.
    a_r5_err_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_we && !mem_we) |=> err_o);

    // R5: an error pulse only follows a suppressed write.
    a_r5_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && err_o) |-> $past(acc_valid && acc_we && !mem_we));

    // R10: valid and address are never altered.
    a_r10_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid == acc_valid) && (mem_addr == acc_addr));
endmodule

// File: rtl/wp_page_guard.sv
// Module: top of the page write-protection unit. Combines the set-only
// mask, the window/page decode and the write gate. The RAM and the bus
// protocol lie outside this block. Assumes NUM_PAGES is 4, 8 or 16.
module wp_page_guard #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned NUM_PAGES = 16,
    parameter logic [ADDR_W-1:0] BASE = 32'h1000_0000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_wr_en,
    input  logic [NUM_PAGES-1:0]  cfg_wr_data,
    output logic [NUM_PAGES-1:0]  prot_mask_o,
    input  logic                  acc_valid,
    input  logic [ADDR_W-1:0]     acc_addr,
    input  logic                  acc_we,
    input  logic [DATA_W/8-1:0]   acc_strb,
    output logic                  mem_valid,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic                  mem_we,
    output logic [DATA_W/8-1:0]   mem_strb,
    output logic                  err_o
);
    localparam int unsigned STRB_W = DATA_W / 8;

    logic [NUM_PAGES-1:0] mask;
    logic [NUM_PAGES-1:0] page_sel;
    logic                 in_window;

    wp_mask_reg #(.NUM_PAGES(NUM_PAGES)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .mask    (mask)
    );

    wp_page_decode #(.ADDR_W(ADDR_W), .NUM_PAGES(NUM_PAGES), .BASE(BASE)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .page_addr (acc_addr[ADDR_W-1:wp_pkg::WP_PAGE_SHIFT]),
        .in_window (in_window),
        .page_sel  (page_sel)
    );

    wp_write_gate #(.ADDR_W(ADDR_W), .STRB_W(STRB_W), .NUM_PAGES(NUM_PAGES)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .page_sel  (page_sel),
        .mask      (mask),
        .acc_valid (acc_valid),
        .acc_addr  (acc_addr),
        .acc_we    (acc_we),
        .acc_strb  (acc_strb),
        .mem_valid (mem_valid),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_strb  (mem_strb),
        .err_o     (err_o)
    );

    assign prot_mask_o = mask;

    // R8: writes outside the window are never suppressed.
    a_r8_outside_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !in_window) |-> (mem_we == acc_we && mem_strb == acc_strb));

    // R1: the cycle after reset the mask is empty and no error is raised.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (prot_mask_o == '0 && !err_o));
endmodule

// File: tb/sim_wp_page_guard.sv
module sim_wp_page_guard;
    localparam int unsigned NP = 8;
    localparam logic [31:0] B  = 32'h1000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [NP-1:0] cfg_wr_data = '0;
    logic [NP-1:0] prot_mask_o;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_we = 1'b0;
    logic [3:0]  acc_strb = '0;
    logic        mem_valid, mem_we, err_o;
    logic [31:0] mem_addr;
    logic [3:0]  mem_strb;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;   // 50 MHz

    wp_page_guard #(.ADDR_W(32), .DATA_W(32), .NUM_PAGES(NP), .BASE(B)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .prot_mask_o(prot_mask_o), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_we(acc_we), .acc_strb(acc_strb), .mem_valid(mem_valid),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_strb(mem_strb), .err_o(err_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary_and_end();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog expired");
            summary_and_end();
        end
    end

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic cfg_write(input logic [NP-1:0] d);
        @(negedge clk); cfg_wr_en = 1'b1; cfg_wr_data = d;
        @(negedge clk); cfg_wr_en = 1'b0; cfg_wr_data = '0;
    endtask

    // Drive one access cycle and check the RAM side and the error pulse.
    task automatic access(input string req, input logic [31:0] a, input logic we,
                          input logic [3:0] s, input logic exp_block);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_we = we; acc_strb = s;
        #1;
        chk({req, " mem_we"},   mem_we,   exp_block ? 1'b0 : we);
        chk({req, " mem_strb"}, mem_strb, exp_block ? 4'h0 : s);
        chk({"R10 addr/valid"}, {mem_valid, mem_addr}, {1'b1, a});
        @(negedge clk);
        acc_valid = 1'b0; acc_we = 1'b0; acc_strb = '0;
        chk({req, " err pulse"}, err_o, exp_block);
        @(negedge clk);
        chk("R5 err one cycle", err_o, 1'b0);
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R1 mask", prot_mask_o, '0);
        chk("R1 err", err_o, 1'b0);
    endtask

    task automatic t_set_bits();
        cfg_write(8'b0000_1000);
        chk("R2 set page3", prot_mask_o, 8'h08);
        cfg_write(8'b1000_0001);
        chk("R2 accumulate", prot_mask_o, 8'h89);
    endtask

    task automatic t_no_clear();
        cfg_write(8'h00);
        chk("R3 zero write", prot_mask_o, 8'h89);
        cfg_write(8'h02);
        chk("R3 partial write keeps", prot_mask_o, 8'h8B);
    endtask

    task automatic t_blocked();
        access("R4 page3 write", B + 32'h0C10, 1'b1, 4'hF, 1'b1);
        access("R4 page7 byte write", B + 32'h1F00, 1'b1, 4'h2, 1'b1);
        access("R7 page2 write", B + 32'h0800, 1'b1, 4'hC, 1'b0);
        access("R7 page5 write", B + 32'h1400, 1'b1, 4'h3, 1'b0);
    endtask

    task automatic t_reads();
        access("R6 read page3", B + 32'h0C00, 1'b0, 4'hF, 1'b0);
        access("R6 read page0", B + 32'h0004, 1'b0, 4'h1, 1'b0);
    endtask

    task automatic t_outside();
        access("R8 alias page3 above window", B + 32'h2C00, 1'b1, 4'hF, 1'b0);
        access("R8 other region", 32'h2000_0C00, 1'b1, 4'hF, 1'b0);
        access("R8 below base", B - 32'h0400, 1'b1, 4'h5, 1'b0);
    endtask

    task automatic t_boundary();
        access("R4 page2 last byte", B + 32'h0BFF, 1'b1, 4'h8, 1'b0);
        access("R4 page3 first byte", B + 32'h0C00, 1'b1, 4'h1, 1'b1);
        access("R4 page3 last byte", B + 32'h0FFF, 1'b1, 4'h8, 1'b1);
        access("R4 page4 first byte", B + 32'h1000, 1'b1, 4'h1, 1'b0);
    endtask

    task automatic t_same_cycle();
        // Set page4 in the same cycle as a write to page4.
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_data = 8'h10;
        acc_valid = 1'b1; acc_addr = B + 32'h1040; acc_we = 1'b1; acc_strb = 4'hF;
        #1;
        chk("R9 same-cycle write passes", {mem_we, mem_strb}, {1'b1, 4'hF});
        @(negedge clk);
        cfg_wr_en = 1'b0; cfg_wr_data = '0;
        acc_valid = 1'b0; acc_we = 1'b0; acc_strb = '0;
        chk("R9 no err", err_o, 1'b0);
        chk("R9 mask updated", prot_mask_o, 8'h9B);
        access("R9 next write blocked", B + 32'h1040, 1'b1, 4'hF, 1'b1);
    endtask

    task automatic t_reset_clears();
        do_reset();
        chk("R3 reset clears", prot_mask_o, '0);
        access("R3 page3 write after reset", B + 32'h0C00, 1'b1, 4'hF, 1'b0);
    endtask

    initial begin
        t_reset_state();
        t_set_bits();
        t_no_clear();
        t_blocked();
        t_reads();
        t_outside();
        t_boundary();
        t_same_cycle();
        t_reset_clears();
        summary_and_end();
    end
endmodule